// File: doc/BRIEF.md
# Serial Address and Flag Loader

After reset, a host CPU sends this block a single configuration frame over two wires: a serial clock and a data line. The block takes one bit on each falling edge of the serial clock and counts exactly 225 of them. The first 33 bits are option flags. They go into a flag register without being interpreted. The remaining 192 bits form six address slots of 32 bits each, in the order A, B, C, D, E, F. Each slot carries an 18-bit address sent most significant bit first, then two function bits, then twelve padding bits that are not kept.

The serial clock and data are brought into the system clock domain by a two-flop synchroniser, and the falling edge is found in that domain. When the 225th bit has been stored, the block pulses `done_o` for one system clock and raises `loaded_o`. From then on it ignores the serial pins until the next reset.

The outputs are a static snapshot qualified by `loaded_o`. There is no stream and no back-pressure, so every pin is a plain level or a pulse. A reset in the middle of a frame throws away the partial load and arms the block for a new frame.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is asserted, and right after it, `done_o` and `loaded_o` are 0 and `flags_o`, `addr_o` and `func_o` are all zero.
- R2: The bits taken on serial falling edges 1 to 33 land in `flags_o`. Edge 1 goes to bit 32 and edge 33 goes to bit 0.
- R3: For slot k (A=0 … F=5), the edges 34+32k to 51+32k fill `addr_o[18k+17:18k]`, most significant bit first.
- R4: For slot k, edges 52+32k and 53+32k fill `func_o[2k+1]` and then `func_o[2k]`.
- R5: Bits on edges 54+32k to 65+32k (the slot padding) change no output, whatever their value.
- R6: `done_o` is high for exactly one system clock. It rises on the third rising system clock edge after the 225th serial falling edge. `loaded_o` rises with it and stays 1, and it stays 0 before edge 225.
- R7: Once `loaded_o` is 1, further serial edges change no output and raise no further `done_o`.
- R8: A reset during a frame leaves `done_o` and `loaded_o` low and clears the captured outputs. The next full frame then loads correctly from edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; arms the loader |
| ser_clk_i | input | 1 | Host serial clock, idles high, asynchronous |
| ser_dat_i | input | 1 | Host serial data, stable around falling edges |
| flags_o | output | 33 | Option flag bits, first received in bit 32 |
| addr_o | output | 108 | Six 18-bit addresses, slot k at bits 18k+17:18k |
| func_o | output | 12 | Six 2-bit function codes, slot k at bits 2k+1:2k |
| done_o | output | 1 | One-clock pulse when the frame completes |
| loaded_o | output | 1 | High once a full frame has been captured |

## Verification
Each falling edge on `ser_clk_i` needs two synchroniser stages and one edge-detect register before it reaches the capture registers. Every stored bit and `done_o` therefore change on the third rising system edge after the serial edge. The driver records the system cycle in which it drops the serial clock and pushes the expected frame into a scoreboard queue before that last edge. The monitor samples on falling system edges, so a result at cycle n+3 is seen with no race. It pops the queue when `done_o` appears and requires a distance of exactly three cycles. The ignore cases are checked in the same way: a settling interval of well over three cycles follows, and then the outputs are compared with the values already held.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned DEF_FLAG_W   = 33;
  localparam int unsigned DEF_N_SLOTS  = 6;
  localparam int unsigned DEF_ADDR_W   = 18;
  localparam int unsigned DEF_FUNC_W   = 2;
  localparam int unsigned DEF_SLOT_LEN = 32;
  localparam int unsigned DEF_SYNC     = 2;

  // Which register the current frame bit belongs to
  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_FLAG = 2'd1,
    FLD_ADDR = 2'd2,
    FLD_FUNC = 2'd3
  } field_e;

  typedef enum logic {
    ST_LOAD = 1'b0,
    ST_FULL = 1'b1
  } ld_state_e;
endpackage

// File: rtl/scl_edge_sync.sv
module scl_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic fall_o,
  output logic bit_o
);
  logic [STAGES-1:0] clk_sh;
  logic [STAGES-1:0] dat_sh;
  logic              clk_d;

  // serial clock idles high: reset to 1 so no false edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh <= '1;
      dat_sh <= '0;
      clk_d  <= 1'b1;
    end else begin
      clk_sh <= {clk_sh[STAGES-2:0], sclk_i};
      dat_sh <= {dat_sh[STAGES-2:0], sdat_i};
      clk_d  <= clk_sh[STAGES-1];
    end
  end

  assign fall_o = clk_d & ~clk_sh[STAGES-1];
  assign bit_o  = dat_sh[STAGES-1];
endmodule

// File: rtl/scl_frame_seq.sv
module scl_frame_seq
  import scl_pkg::*;
#(
  parameter int unsigned FLAG_W   = DEF_FLAG_W,
  parameter int unsigned N_SLOTS  = DEF_N_SLOTS,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned FUNC_W   = DEF_FUNC_W,
  parameter int unsigned SLOT_LEN = DEF_SLOT_LEN,
  localparam int unsigned FRAME_LEN = FLAG_W + N_SLOTS * SLOT_LEN,
  localparam int unsigned CNT_W  = $clog2(FRAME_LEN + 1),
  localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int unsigned OFF_W  = $clog2(SLOT_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  output logic              take_o,
  output field_e            field_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              done_o,
  output logic              loaded_o
);
  ld_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rel;
  logic [OFF_W-1:0] off;

  assign take_o = fall_i && (state == ST_LOAD);

  // decode the position of the next bit in the frame
  always_comb begin
    rel     = cnt - CNT_W'(FLAG_W);
    off     = OFF_W'(rel % CNT_W'(SLOT_LEN));
    slot_o  = SLOT_W'(rel / CNT_W'(SLOT_LEN));
    field_o = FLD_NONE;
    if (cnt < CNT_W'(FLAG_W)) begin
      field_o = FLD_FLAG;
      slot_o  = '0;
    end else if (off < OFF_W'(ADDR_W)) begin
      field_o = FLD_ADDR;
    end else if (off < OFF_W'(ADDR_W + FUNC_W)) begin
      field_o = FLD_FUNC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_LOAD;
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take_o) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(FRAME_LEN - 1)) begin
          state  <= ST_FULL;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign loaded_o = (state == ST_FULL);
endmodule

// File: rtl/scl_field_store.sv
module scl_field_store
  import scl_pkg::*;
#(
  parameter int unsigned FLAG_W  = DEF_FLAG_W,
  parameter int unsigned N_SLOTS = DEF_N_SLOTS,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned FUNC_W  = DEF_FUNC_W,
  localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take_i,
  input  field_e                      field_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic                        bit_i,
  output logic [FLAG_W-1:0]           flags_o,
  output logic [N_SLOTS*ADDR_W-1:0]   addr_o,
  output logic [N_SLOTS*FUNC_W-1:0]   func_o
);
  // flags: shift in, first bit ends up at the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else if (take_i && field_i == FLD_FLAG)
      flags_o <= {flags_o[FLAG_W-2:0], bit_i};
  end

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    logic hit;
    assign hit = take_i && (slot_i == SLOT_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_o[k*ADDR_W +: ADDR_W] <= '0;
        func_o[k*FUNC_W +: FUNC_W] <= '0;
      end else if (hit && field_i == FLD_ADDR) begin
        addr_o[k*ADDR_W +: ADDR_W] <= {addr_o[k*ADDR_W +: ADDR_W-1], bit_i};
      end else if (hit && field_i == FLD_FUNC) begin
        func_o[k*FUNC_W +: FUNC_W] <= {func_o[k*FUNC_W +: FUNC_W-1], bit_i};
      end
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import scl_pkg::*;
#(
  parameter int unsigned FLAG_W   = DEF_FLAG_W,
  parameter int unsigned N_SLOTS  = DEF_N_SLOTS,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned FUNC_W   = DEF_FUNC_W,
  parameter int unsigned SLOT_LEN = DEF_SLOT_LEN,
  parameter int unsigned SYNC     = DEF_SYNC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk_i,
  input  logic                      ser_dat_i,
  output logic [FLAG_W-1:0]         flags_o,
  output logic [N_SLOTS*ADDR_W-1:0] addr_o,
  output logic [N_SLOTS*FUNC_W-1:0] func_o,
  output logic                      done_o,
  output logic                      loaded_o
);
  localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  logic              fall;
  logic              sbit;
  logic              take;
  field_e            field;
  logic [SLOT_W-1:0] slot;

  scl_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (ser_clk_i),
    .sdat_i (ser_dat_i),
    .fall_o (fall),
    .bit_o  (sbit)
  );

  scl_frame_seq #(
    .FLAG_W(FLAG_W), .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W),
    .FUNC_W(FUNC_W), .SLOT_LEN(SLOT_LEN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_i   (fall),
    .take_o   (take),
    .field_o  (field),
    .slot_o   (slot),
    .done_o   (done_o),
    .loaded_o (loaded_o)
  );

  scl_field_store #(
    .FLAG_W(FLAG_W), .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .FUNC_W(FUNC_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .field_i (field),
    .slot_i  (slot),
    .bit_i   (sbit),
    .flags_o (flags_o),
    .addr_o  (addr_o),
    .func_o  (func_o)
  );
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
  parameter int unsigned FLAG_W  = 33,
  parameter int unsigned N_SLOTS = 6,
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned FUNC_W  = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [FLAG_W-1:0]         flags_o,
  input logic [N_SLOTS*ADDR_W-1:0] addr_o,
  input logic [N_SLOTS*FUNC_W-1:0] func_o,
  input logic                      done_o,
  input logic                      loaded_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_LOADED_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded_o) |-> done_o); // R6
  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_o |=> loaded_o); // R7
  AST_NO_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_o && $past(loaded_o)) |-> !done_o); // R7
  AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_o && $past(loaded_o)) |-> $stable(flags_o)); // R7
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_o && $past(loaded_o)) |-> ($stable(addr_o) && $stable(func_o))); // R7
endmodule

bind serial_cfg_loader scl_checker #(
  .FLAG_W(FLAG_W), .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .FUNC_W(FUNC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flags_o  (flags_o),
  .addr_o   (addr_o),
  .func_o   (func_o),
  .done_o   (done_o),
  .loaded_o (loaded_o)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  localparam int FLAG_W = 33;
  localparam int NS     = 6;
  localparam int AW     = 18;
  localparam int FW     = 2;
  localparam int SLEN   = 32;
  localparam int FRAME  = FLAG_W + NS * SLEN;
  localparam int HALF   = 6;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ser_clk, ser_dat;
  logic [FLAG_W-1:0] flags_o;
  logic [NS*AW-1:0]  addr_o;
  logic [NS*FW-1:0]  func_o;
  logic done_o, loaded_o;

  serial_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .flags_o(flags_o), .addr_o(addr_o), .func_o(func_o),
    .done_o(done_o), .loaded_o(loaded_o)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_done = 0;

  typedef struct {
    logic [FLAG_W-1:0] fl;
    logic [NS*AW-1:0]  ad;
    logic [NS*FW-1:0]  fu;
    int unsigned       t;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic fbit(input int i, input logic [FLAG_W-1:0] fl,
      input logic [NS*AW-1:0] ad, input logic [NS*FW-1:0] fu, input logic pad);
    int rel, k, off;
    if (i < FLAG_W) return fl[FLAG_W-1-i];
    rel = i - FLAG_W; k = rel / SLEN; off = rel % SLEN;
    if (off < AW) return ad[k*AW + AW-1-off];
    if (off < AW + FW) return fu[k*FW + AW+FW-1-off];
    return pad;
  endfunction

  // driver: n serial bits; optionally push expected result at the last edge
  task automatic drive(input int n, input logic [FLAG_W-1:0] fl,
      input logic [NS*AW-1:0] ad, input logic [NS*FW-1:0] fu,
      input logic pad, input bit push);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_clk = 1'b1;
      ser_dat = fbit(i, fl, ad, fu, pad);
      repeat (HALF) @(negedge clk);
      if (push && i == n-1) begin
        exp_t e;
        e.fl = fl; e.ad = ad; e.fu = fu; e.t = cyc;
        sbq.push_back(e);
      end
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    @(negedge clk);
    ser_clk = 1'b1;
  endtask

  // monitor: compare each done pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      n_done++;
      if (sbq.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(cyc - e.t == LAT, "R6 done latency", cyc - e.t, LAT);
        chk(flags_o == e.fl, "R2 flags", flags_o, e.fl);
        chk(addr_o == e.ad, "R3 addresses", addr_o, e.ad);
        chk(func_o == e.fu, "R4 function bits", func_o, e.fu);
        chk(loaded_o == 1'b1, "R6 loaded with done", loaded_o, 1);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_cleared(input string req);
    chk(done_o == 1'b0, req, done_o, 0);
    chk(loaded_o == 1'b0, req, loaded_o, 0);
    chk(flags_o == '0, req, flags_o, 0);
    chk(addr_o == '0, req, addr_o, 0);
    chk(func_o == '0, req, func_o, 0);
  endtask

  task automatic make_frame(input int seed, output logic [FLAG_W-1:0] fl,
      output logic [NS*AW-1:0] ad, output logic [NS*FW-1:0] fu);
    fl = {1'b1, 32'h0F0F_5A5A ^ (32'h1357_9BDF * seed)};
    for (int k = 0; k < NS; k++) begin
      ad[k*AW +: AW] = 18'h2AAAA ^ AW'((k + 1) * 18'h0B3C5 * (seed + 1));
      fu[k*FW +: FW] = FW'(k + seed);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  logic [FLAG_W-1:0] f1, f2, f3;
  logic [NS*AW-1:0]  a1, a2, a3;
  logic [NS*FW-1:0]  u1, u2, u3;

  initial begin
    rst_n = 1'b0; ser_clk = 1'b1; ser_dat = 1'b0;
    repeat (4) @(negedge clk);
    check_cleared("R1 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_cleared("R1 after reset release");

    // frame 1, zero padding
    make_frame(1, f1, a1, u1);
    drive(FRAME - 1, f1, a1, u1, 1'b0, 1'b0);
    chk(loaded_o == 1'b0, "R6 not loaded before last edge", loaded_o, 0);
    @(negedge clk); ser_clk = 1'b1;
    // restart cannot resend: drive only the final bit by position
    for (int i = FRAME - 1; i < FRAME; i++) begin
      ser_dat = fbit(i, f1, a1, u1, 1'b0);
      repeat (HALF) @(negedge clk);
      begin
        exp_t e;
        e.fl = f1; e.ad = a1; e.fu = u1; e.t = cyc;
        sbq.push_back(e);
      end
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
    end
    repeat (10) @(negedge clk);
    chk(loaded_o == 1'b1, "R6 loaded holds", loaded_o, 1);

    // R7: extra edges after completion are ignored
    drive(40, ~f1, ~a1, ~u1, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(flags_o == f1, "R7 flags kept", flags_o, f1);
    chk(addr_o == a1, "R7 addresses kept", addr_o, a1);
    chk(func_o == u1, "R7 function bits kept", func_o, u1);
    chk(n_done == 1, "R7 single done", n_done, 1);

    // frame 2 with ones in padding
    do_reset();
    check_cleared("R1 reset after load");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    make_frame(2, f2, a2, u2);
    drive(FRAME, f2, a2, u2, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    chk(addr_o == a2, "R5 padding ignored in addresses", addr_o, a2);
    chk(func_o == u2, "R5 padding ignored in function bits", func_o, u2);

    // R8: reset in the middle of a frame
    do_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    make_frame(3, f3, a3, u3);
    drive(100, ~f3, ~a3, ~u3, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk(loaded_o == 1'b0, "R8 partial frame not loaded", loaded_o, 0);
    do_reset();
    check_cleared("R8 cleared by mid-frame reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(FRAME, f3, a3, u3, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk(addr_o == a3, "R8 fresh load after abort", addr_o, a3);
    chk(n_done == 3, "R6 done count", n_done, 3);
    chk(sbq.size() == 0, "R6 all frames completed", sbq.size(), 0);

    summary();
    $finish;
  end
endmodule